// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits beside one processor and decides which single interrupt is presented to it. It holds five pieces of state: the processor's current priority threshold, the priority of the pending inter-processor interrupt, the priority of whatever is pending, the pending source number and a flag that records a refused delivery. Lower numbers mean more urgent. The interrupt line is high while a source is pending that is more urgent than the current threshold.

Source controllers offer interrupts, and each offer is either taken or refused. A source that is pushed out of the pending slot is handed back on the reject output so that it can be offered again. The processor issues four commands: accept, set threshold, set inter-processor priority and end-of-interrupt. Whenever the processor makes a priority less strict, a resend pulse tells the source side to re-offer anything that was refused. End-of-interrupt words have their source number passed on to the source controller.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the threshold is 0, the inter-processor priority and the pending priority are 0xFF, the pending source is 0, the refusal flag is clear, and every output is low.
- R2: `irq_out` is high exactly when the pending source is nonzero and the pending priority is numerically below the threshold.
- R3: An offer of priority p is taken (`offer_ok`=1) only when the threshold, the inter-processor priority and the pending priority are all greater than p. A refused offer sets the refusal flag.
- R4: A taken offer replaces the pending source and priority, and the source it replaces is returned on the reject output.
- R5: Accept (`cmd_op`=0) returns the word {threshold[7:0], pending source[23:0]}. When the pending source is nonzero, the threshold takes the pending priority, the pending priority becomes 0xFF and the pending source is cleared.
- R6: Set inter-processor priority (`cmd_op`=2, value in `cmd_data[7:0]`) loads the value. When the value is below the threshold and not above the pending priority, the pending source is rejected, the pending priority becomes the value and the pending source becomes 2.
- R7: When the inter-processor priority is set to a numerically larger value than it had, the refusal flag is copied onto `resend_req` and then cleared.
- R8: Set threshold (`cmd_op`=1, value in `cmd_data[7:0]`) to the current value changes nothing. A larger value lowers the threshold: the threshold is loaded, source 2 is presented if the inter-processor priority is below the new threshold and not above the pending priority, and the refusal flag is copied onto `resend_req` and cleared.
- R9: Set threshold to a smaller value loads it. When the new value is not above the pending priority, the pending source is rejected and cleared and the pending priority becomes 0xFF.
- R10: End-of-interrupt (`cmd_op`=3) lowers the threshold as in R8 using `cmd_data[31:24]`, and forwards `cmd_data[23:0]` on `eoi_src` unless that number is 2.
- R11: A rejected value of 0 or 2 raises no `reject_valid`.
- R12: A command and an offer in the same cycle: the command is carried out, the offer is refused and the refusal flag is left set.
- R13: Every response appears in the cycle after its request and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | Processor command present |
| cmd_op | input | 2 | 0 accept, 1 set threshold, 2 set inter-processor priority, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| offer_done | output | 1 | Offer response valid |
| offer_ok | output | 1 | Offer was taken |
| acc_valid | output | 1 | Accept result valid |
| acc_word | output | 32 | Threshold and pending source before the accept |
| reject_valid | output | 1 | A source was pushed out |
| reject_src | output | 24 | Number of the rejected source |
| resend_req | output | 1 | Re-offer request to the source side |
| eoi_valid | output | 1 | End-of-interrupt forward valid |
| eoi_src | output | 24 | Source number being completed |

## Verification
The properties assume that offered source numbers are never 0 and never the inter-processor number 2. With that assumption, a taken offer must raise the interrupt line and any reject that is raised carries a real source. The stimulus draws offer sources only from ranges above 2, while end-of-interrupt words deliberately use both 2 and ordinary numbers. Priorities are swept over a small set that includes 0, 0xFF and values on each side of typical thresholds, so every comparison is exercised with equal, smaller and larger operands.

// File: rtl/irq_present_unit.sv
module irq_present_unit #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              irq_out,
  output logic              offer_done,
  output logic              offer_ok,
  output logic              acc_valid,
  output logic [WORD_W-1:0] acc_word,
  output logic              reject_valid,
  output logic [SRC_W-1:0]  reject_src,
  output logic              resend_req,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src
);
  localparam logic [1:0] OP_ACCEPT = 2'd0;
  localparam logic [1:0] OP_THRESH = 2'd1;
  localparam logic [1:0] OP_IPRIO  = 2'd2;
  localparam logic [1:0] OP_EOI    = 2'd3;
  localparam logic [PRIO_W-1:0] LEAST = '1;
  localparam logic [SRC_W-1:0]  IPI   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] thr_q, ipr_q, pend_pri_q;
  logic [SRC_W-1:0]  pend_src_q;
  logic              refused_q;

  logic [PRIO_W-1:0] thr_d, ipr_d, pend_pri_d;
  logic [SRC_W-1:0]  pend_src_d;
  logic              refused_d;

  logic [SRC_W-1:0]  rej_d, eoi_src_d;
  logic              resend_d, acc_d, eoi_d, done_d, ok_d;
  logic              lower_en;
  logic [PRIO_W-1:0] lower_val;

  wire [PRIO_W-1:0] arg   = cmd_data[PRIO_W-1:0];
  wire [PRIO_W-1:0] hi    = cmd_data[WORD_W-1:SRC_W];
  wire [SRC_W-1:0]  lo    = cmd_data[SRC_W-1:0];
  wire              fits  = (thr_q > offer_prio) && (ipr_q > offer_prio) &&
                            (pend_pri_q > offer_prio);

  assign irq_out = (pend_src_q != '0) && (pend_pri_q < thr_q);

  always_comb begin
    thr_d      = thr_q;
    ipr_d      = ipr_q;
    pend_pri_d = pend_pri_q;
    pend_src_d = pend_src_q;
    refused_d  = refused_q;
    rej_d      = '0;
    resend_d   = 1'b0;
    acc_d      = 1'b0;
    eoi_d      = 1'b0;
    eoi_src_d  = '0;
    done_d     = 1'b0;
    ok_d       = 1'b0;
    lower_en   = 1'b0;
    lower_val  = '0;

    if (cmd_valid) begin
      unique case (cmd_op)
        OP_ACCEPT: begin
          acc_d = 1'b1;
          if (pend_src_q != '0) begin
            thr_d      = pend_pri_q;
            pend_pri_d = LEAST;
            pend_src_d = '0;
          end
        end
        OP_THRESH: begin
          if (arg > thr_q) begin
            lower_en  = 1'b1;
            lower_val = arg;
          end else if (arg < thr_q) begin
            thr_d = arg;
            if (arg <= pend_pri_q) begin
              rej_d      = pend_src_q;
              pend_src_d = '0;
              pend_pri_d = LEAST;
            end
          end
        end
        OP_IPRIO: begin
          ipr_d = arg;
          if (arg < thr_q && arg <= pend_pri_q) begin
            rej_d      = pend_src_q;
            pend_pri_d = arg;
            pend_src_d = IPI;
          end
          if (arg > ipr_q) begin
            resend_d  = refused_q;
            refused_d = 1'b0;
          end
        end
        OP_EOI: begin
          lower_en  = 1'b1;
          lower_val = hi;
          if (lo != IPI) begin
            eoi_d     = 1'b1;
            eoi_src_d = lo;
          end
        end
        default: ;
      endcase
    end

    if (lower_en) begin
      thr_d = lower_val;
      if (ipr_q < lower_val && ipr_q <= pend_pri_q) begin
        pend_pri_d = ipr_q;
        pend_src_d = IPI;
      end
      resend_d  = refused_q;
      refused_d = 1'b0;
    end

    if (offer_valid) begin
      done_d = 1'b1;
      if (cmd_valid) begin
        refused_d = 1'b1;
      end else if (fits) begin
        ok_d       = 1'b1;
        rej_d      = pend_src_q;
        pend_src_d = offer_src;
        pend_pri_d = offer_prio;
      end else begin
        refused_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q        <= '0;
      ipr_q        <= LEAST;
      pend_pri_q   <= LEAST;
      pend_src_q   <= '0;
      refused_q    <= 1'b0;
      offer_done   <= 1'b0;
      offer_ok     <= 1'b0;
      acc_valid    <= 1'b0;
      acc_word     <= '0;
      reject_valid <= 1'b0;
      reject_src   <= '0;
      resend_req   <= 1'b0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
    end else begin
      thr_q        <= thr_d;
      ipr_q        <= ipr_d;
      pend_pri_q   <= pend_pri_d;
      pend_src_q   <= pend_src_d;
      refused_q    <= refused_d;
      offer_done   <= done_d;
      offer_ok     <= ok_d;
      acc_valid    <= acc_d;
      acc_word     <= acc_d ? {thr_q, pend_src_q} : '0;
      reject_valid <= (rej_d != '0) && (rej_d != IPI);
      reject_src   <= rej_d;
      resend_req   <= resend_d;
      eoi_valid    <= eoi_d;
      eoi_src      <= eoi_src_d;
    end
  end
endmodule

// File: rtl/irq_present_unit_chk.sv
module irq_present_unit_chk #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              offer_valid,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [PRIO_W-1:0] cmd_prio,
  input logic              irq_out,
  input logic              offer_done,
  input logic              offer_ok,
  input logic              acc_valid,
  input logic              reject_valid,
  input logic [SRC_W-1:0]  reject_src,
  input logic              resend_req,
  input logic              eoi_valid,
  input logic [SRC_W-1:0]  eoi_src
);
  localparam logic [SRC_W-1:0] IPI = SRC_W'(IPI_SRC);

  p_accept_quiets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd0 |=> !irq_out);

  p_strict_thr_quiets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 && cmd_prio == '0 |=> !irq_out);

  p_taken_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    offer_ok |-> irq_out && offer_done);

  p_collide_refused_r12: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && cmd_valid |=> offer_done && !offer_ok);

  p_offer_answered_r13: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |=> offer_done);

  p_no_stray_answer_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !offer_valid |=> !offer_done);

  p_acc_origin_r13: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(cmd_valid && cmd_op == 2'd0));

  p_reject_real_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reject_valid |-> reject_src != '0 && reject_src != IPI);

  p_eoi_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(cmd_valid && cmd_op == 2'd3) && eoi_src != IPI);

  p_resend_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |-> $past(cmd_valid && cmd_op != 2'd0));
endmodule

bind irq_present_unit irq_present_unit_chk #(
  .PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_prio(cmd_data[PRIO_W-1:0]), .irq_out(irq_out),
  .offer_done(offer_done), .offer_ok(offer_ok), .acc_valid(acc_valid),
  .reject_valid(reject_valid), .reject_src(reject_src), .resend_req(resend_req),
  .eoi_valid(eoi_valid), .eoi_src(eoi_src)
);

// File: tb/irq_present_unit_tb.sv
`timescale 1ns/1ps
module irq_present_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        irq_out, offer_done, offer_ok, acc_valid, reject_valid, resend_req, eoi_valid;
  logic [31:0] acc_word;
  logic [23:0] reject_src, eoi_src;

  always #2.5 clk = ~clk;

  irq_present_unit dut_i (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_prio(offer_prio), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .irq_out(irq_out), .offer_done(offer_done), .offer_ok(offer_ok),
    .acc_valid(acc_valid), .acc_word(acc_word), .reject_valid(reject_valid),
    .reject_src(reject_src), .resend_req(resend_req), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0]  m_thr, m_ipr, m_ppri;
  logic [23:0] m_src;
  bit          m_ref;
  bit          e_done, e_ok, e_acc, e_res, e_eoi, e_rej;
  logic [31:0] e_word;
  logic [23:0] e_es, rv;
  logic [7:0]  pv [9];

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic mlower(input logic [7:0] v);
    m_thr = v;
    if (m_ipr < v && m_ipr <= m_ppri) begin
      m_ppri = m_ipr;
      m_src  = 24'd2;
    end
    e_res = m_ref;
    m_ref = 1'b0;
  endtask

  task automatic step(input bit ov, input logic [23:0] os, input logic [7:0] op_p,
                      input bit cv, input logic [1:0] op, input logic [31:0] d,
                      input string tag);
    logic [7:0] v;
    e_done = 0; e_ok = 0; e_acc = 0; e_res = 0; e_eoi = 0; e_word = '0; e_es = '0; rv = '0;
    offer_valid = ov; offer_src = os; offer_prio = op_p;
    cmd_valid = cv; cmd_op = op; cmd_data = d;
    v = d[7:0];
    if (cv) begin
      case (op)
        2'd0: begin
          e_acc = 1; e_word = {m_thr, m_src};
          if (m_src != 0) begin m_thr = m_ppri; m_ppri = 8'hFF; m_src = '0; end
        end
        2'd1: begin
          if (v > m_thr) mlower(v);
          else if (v < m_thr) begin
            m_thr = v;
            if (v <= m_ppri) begin rv = m_src; m_src = '0; m_ppri = 8'hFF; end
          end
        end
        2'd2: begin
          if (v < m_thr && v <= m_ppri) begin rv = m_src; m_ppri = v; m_src = 24'd2; end
          if (v > m_ipr) begin e_res = m_ref; m_ref = 1'b0; end
          m_ipr = v;
        end
        default: begin
          mlower(d[31:24]);
          if (d[23:0] != 24'd2) begin e_eoi = 1; e_es = d[23:0]; end
        end
      endcase
    end
    if (ov) begin
      e_done = 1;
      if (cv) m_ref = 1'b1;
      else if (m_thr > op_p && m_ipr > op_p && m_ppri > op_p) begin
        e_ok = 1; rv = m_src; m_src = os; m_ppri = op_p;
      end else m_ref = 1'b1;
    end
    e_rej = (rv != 0) && (rv != 24'd2);
    @(posedge clk);
    @(negedge clk);
    offer_valid = 1'b0; cmd_valid = 1'b0;
    chk(tag, "irq_out (R2)", {31'd0, irq_out}, {31'd0, (m_src != 0) && (m_ppri < m_thr)});
    chk(tag, "offer_done (R13)", {31'd0, offer_done}, {31'd0, e_done});
    chk(tag, "offer_ok (R3)", {31'd0, offer_ok}, {31'd0, e_ok});
    chk(tag, "acc_valid (R5)", {31'd0, acc_valid}, {31'd0, e_acc});
    if (e_acc) chk(tag, "acc_word (R5)", acc_word, e_word);
    chk(tag, "reject_valid (R4 R11)", {31'd0, reject_valid}, {31'd0, e_rej});
    if (e_rej) chk(tag, "reject_src (R4)", {8'd0, reject_src}, {8'd0, rv});
    chk(tag, "resend_req (R7 R8)", {31'd0, resend_req}, {31'd0, e_res});
    chk(tag, "eoi_valid (R10)", {31'd0, eoi_valid}, {31'd0, e_eoi});
    if (e_eoi) chk(tag, "eoi_src (R10)", {8'd0, eoi_src}, {8'd0, e_es});
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lf;
    pv = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h08, 8'h80, 8'hFE, 8'hFF};
    m_thr = 8'h00; m_ipr = 8'hFF; m_ppri = 8'hFF; m_src = '0; m_ref = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "irq_out after reset", {31'd0, irq_out}, 32'd0);
    chk("R1", "valids after reset", {27'd0, offer_done, acc_valid, reject_valid, resend_req, eoi_valid}, 32'd0);

    step(0, 0, 0, 1, 2'd0, 32'd0, "R1");
    step(0, 0, 0, 1, 2'd1, 32'h00, "R8");
    step(0, 0, 0, 1, 2'd1, 32'hFF, "R8");
    step(1, 24'h10, 8'hFE, 0, 0, 0, "R1");
    step(1, 24'h11, 8'h40, 0, 0, 0, "R4");
    step(1, 24'h12, 8'h40, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 2'd2, 32'h80, "R7");
    step(0, 0, 0, 1, 2'd2, 32'h90, "R7");
    step(1, 24'h13, 8'h90, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 2'd2, 32'h10, "R6");
    step(0, 0, 0, 1, 2'd2, 32'h05, "R11");
    step(0, 0, 0, 1, 2'd0, 32'd0, "R5");
    step(0, 0, 0, 1, 2'd1, 32'h01, "R11");
    step(0, 0, 0, 1, 2'd1, 32'h80, "R8");
    step(1, 24'h20, 8'h03, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 2'd1, 32'h03, "R9");
    step(1, 24'h21, 8'h07, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 2'd3, {8'hFF, 24'h20}, "R10");
    step(0, 0, 0, 1, 2'd3, {8'h10, 24'h02}, "R10");
    step(1, 24'h22, 8'h00, 1, 2'd2, 32'hFF, "R12");
    step(0, 0, 0, 1, 2'd1, 32'hFF, "R12");
    step(0, 0, 0, 0, 0, 0, "R13");

    for (int c = 0; c < 9; c++)
      for (int m = 0; m < 9; m++)
        for (int p = 0; p < 9; p++) begin
          step(0, 0, 0, 1, 2'd2, {24'd0, pv[m]}, "R6");
          step(0, 0, 0, 1, 2'd1, {24'd0, pv[c]}, "R9");
          step(1, 24'h100 + 24'(p), pv[p], 0, 0, 0, "R3");
          step(1, 24'h300 + 24'(c), pv[(p + 3) % 9], ((c + m + p) % 4) == 0, 2'd0, 0, "R12");
          step(0, 0, 0, 1, 2'd0, 0, "R5");
          step(0, 0, 0, 1, 2'd3, {pv[c], (p % 3 == 0) ? 24'd2 : 24'h100 + 24'(p)}, "R10");
        end

    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], 24'h40 + 24'(lf[6:3]), pv[lf[10:7] % 9], lf[1], lf[12:11],
           {pv[lf[15:12] % 9], lf[2] ? 24'd2 : 24'h40 + 24'(lf[9:6])}, "R12");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule